// File: doc/BRIEF.md
# Bounded Descending Stack Controller

This block keeps a small last-in first-out stack for a processor-style datapath. The stack lives in a word array inside the block and is tracked through a 16-bit stack pointer that counts downward. When the stack is empty the pointer rests at 0x4000, and no word is ever stored at that address. A push first moves the pointer down by one and then writes the word at the new address. A pop first returns the word at the pointer and then moves the pointer up by one. As a result, the pointer names the current top entry whenever the stack holds data.

Each request is a one-cycle strobe. The block answers every request cycle with an acknowledge pulse and a status bit: 0 means the operation was performed, 1 means it was refused as an overflow or an underflow. A refused operation changes neither the pointer nor the stored words. The fill level and the empty and full flags are worked out from the pointer. The pop data output keeps its value until the next successful pop.

Top module: `stack_ctrl`

## Requirements
- R1: After reset, sp_o is 0x4000, count_o is 0, empty_o is 1, full_o is 0, and ack_o, err_o and rdata_o are all 0.
- R2: A push on a non-full stack makes sp_o one lower, stores wdata_i as the new top and returns ack_o=1 and err_o=0 in the cycle after the request.
- R3: A pop on a non-empty stack presents the top word on rdata_o, makes sp_o one higher and returns ack_o=1 and err_o=0 in the cycle after the request.
- R4: A pop while sp_o is 0x4000 is an underflow: it returns ack_o=1 with err_o=1, and sp_o and rdata_o stay unchanged.
- R5: A push while sp_o is 0x3FFB is an overflow: it returns ack_o=1 with err_o=1 and changes nothing, so the stack holds at most five words (0x3FFF down to 0x3FFB).
- R6: Words come out in the reverse of the order in which they went in.
- R7: count_o equals 0x4000 minus sp_o, empty_o is 1 only at 0x4000, full_o is 1 only at 0x3FFB, and sp_o never leaves the range 0x3FFB..0x4000.
- R8: If push_i and pop_i are both high, only the push is performed and the pop is dropped, so rdata_o does not change. ack_o pulses for exactly one cycle per request cycle and is 0 after a cycle with no request.
- R9: rdata_o keeps the last popped word until the next successful pop, whatever pushes or refused pops happen in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Push request strobe |
| pop_i | input | 1 | Pop request strobe |
| wdata_i | input | 16 | Word to push |
| ack_o | output | 1 | Request completed (one cycle after the request) |
| err_o | output | 1 | Status of the completed request: 1 means overflow or underflow |
| rdata_o | output | 16 | Last popped word |
| sp_o | output | 16 | Stack pointer (address of the top entry) |
| count_o | output | 3 | Number of stored words |
| empty_o | output | 1 | Stack holds no words |
| full_o | output | 1 | Stack holds five words |

## Verification
The state that matters here is the fill level. If it is wrong by even one, sp_o, count_o and the flags disagree with the reference in the same cycle, and every pop after that either reads the wrong slot, which shows up on rdata_o, or is refused with the wrong status. A write that goes to the wrong slot does not show up at the ports until that slot is popped. For that reason the sequences fill the stack completely and then drain it, so every stored word passes through rdata_o. Cases where both requests arrive at the edges of the range check that a refused operation really changed nothing.

// File: rtl/stack_pkg.sv
package stack_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_PUSH   = 2'd1,
    OP_POP    = 2'd2,
    OP_REFUSE = 2'd3
  } stack_op_e;
endpackage

// File: rtl/stack_level.sv
module stack_level #(
  parameter int          PTR_W     = 16,
  parameter int          DEPTH     = 5,
  parameter logic [15:0] EMPTY_PTR = 16'h4000,
  localparam int         CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] level_o,
  output logic [PTR_W-1:0] sp_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [CNT_W-1:0] level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    level_q <= '0;
    else if (dec_i) level_q <= level_q + 1'b1;
    else if (inc_i) level_q <= level_q - 1'b1;
  end

  assign level_o = level_q;
  assign sp_o    = PTR_W'(EMPTY_PTR) - PTR_W'(level_q);
  assign empty_o = (level_q == '0);
  assign full_o  = (level_q == CNT_W'(DEPTH));

  AST_NO_DOUBLE_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && inc_i)) else $error("pointer moved both ways"); // R8
  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_q <= CNT_W'(DEPTH)) else $error("level out of range"); // R7
endmodule

// File: rtl/stack_store.sv
module stack_store #(
  parameter int  DATA_W = 16,
  parameter int  DEPTH  = 5,
  localparam int IDX_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];

  AST_WRITE_IN_RANGE: assert property (@(posedge clk_i)
    we_i |-> (widx_i < IDX_W'(DEPTH))) else $error("write outside store"); // R5
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          PTR_W     = 16,
  parameter int          DEPTH     = 5,
  parameter logic [15:0] EMPTY_PTR = 16'h4000,
  localparam int         CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              empty_o,
  output logic              full_o
);
  stack_op_e         op;
  logic [CNT_W-1:0]  level;
  logic [DATA_W-1:0] top_word;
  logic              ack_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  // push has priority; the pop strobe is dropped when both are high
  always_comb begin
    op = OP_IDLE;
    if (push_i)     op = full_o  ? OP_REFUSE : OP_PUSH;
    else if (pop_i) op = empty_o ? OP_REFUSE : OP_POP;
  end

  stack_level #(
    .PTR_W(PTR_W), .DEPTH(DEPTH), .EMPTY_PTR(EMPTY_PTR)
  ) u_level (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dec_i   (op == OP_PUSH),
    .inc_i   (op == OP_POP),
    .level_o (level),
    .sp_o    (sp_o),
    .empty_o (empty_o),
    .full_o  (full_o)
  );

  // slot k holds address EMPTY_PTR-1-k: new top at slot level, current top at level-1
  stack_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH)
  ) u_store (
    .clk_i   (clk_i),
    .we_i    (op == OP_PUSH),
    .widx_i  (level),
    .wdata_i (wdata_i),
    .ridx_i  (level - 1'b1),
    .rdata_o (top_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= (op != OP_IDLE);
      err_q <= (op == OP_REFUSE);
      if (op == OP_POP) rdata_q <= top_word;
    end
  end

  assign ack_o   = ack_q;
  assign err_o   = err_q;
  assign rdata_o = rdata_q;
  assign count_o = level;

  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o) |=> (sp_o == $past(sp_o) - 1'b1) && !err_o) else $error("push"); // R2
  AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o) |=> (sp_o == $past(sp_o) + 1'b1) && !err_o) else $error("pop"); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty_o) |=> err_o && $stable(sp_o) && $stable(rdata_o)) else $error("underflow"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> err_o && $stable(sp_o)) else $error("overflow"); // R5
  AST_SP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_o <= PTR_W'(EMPTY_PTR)) && (sp_o >= PTR_W'(EMPTY_PTR) - PTR_W'(DEPTH))) else $error("sp range"); // R7
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pop_i) |=> ack_o) else $error("missing ack"); // R8
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i || pop_i) |=> !ack_o && !err_o) else $error("spurious ack"); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && !push_i && !empty_o) |=> $stable(rdata_o)) else $error("rdata moved"); // R9
endmodule

// File: tb/stack_ctrl_bench.sv
module stack_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0, pop_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic        ack_o, err_o, empty_o, full_o;
  logic [15:0] rdata_o, sp_o;
  logic [2:0]  count_o;

  int tests = 0, fails = 0;
  logic [15:0] q[$];
  logic        e_ack = 0, e_err = 0;
  logic [15:0] e_rdata = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk_i = ~clk_i;

  stack_ctrl u_stack_ctrl (
    .clk_i, .rst_ni, .push_i, .pop_i, .wdata_i,
    .ack_o, .err_o, .rdata_o, .sp_o, .count_o, .empty_o, .full_o
  );

  task automatic check(string tag);
    logic [15:0] e_sp;
    e_sp = 16'h4000 - 16'(q.size());
    tests++;
    if (ack_o !== e_ack || err_o !== e_err || rdata_o !== e_rdata || sp_o !== e_sp ||
        count_o !== 3'(q.size()) || empty_o !== (q.size() == 0) || full_o !== (q.size() == 5)) begin
      fails++;
      $display("FAIL %s: ack/err/rdata/sp/cnt/empty/full got %0b %0b %h %h %0d %0b %0b exp %0b %0b %h %h %0d %0b %0b",
               tag, ack_o, err_o, rdata_o, sp_o, count_o, empty_o, full_o,
               e_ack, e_err, e_rdata, e_sp, q.size(), q.size() == 0, q.size() == 5);
    end
  endtask

  task automatic step(bit psh, bit pp, logic [15:0] d, string tag);
    @(negedge clk_i);
    push_i = psh; pop_i = pp; wdata_i = d;
    e_ack = psh | pp;
    e_err = 1'b0;
    if (psh) begin
      if (q.size() == 5) e_err = 1'b1;
      else q.push_front(d);
    end else if (pp) begin
      if (q.size() == 0) e_err = 1'b1;
      else e_rdata = q.pop_front();
    end
    @(posedge clk_i); #1;
    push_i = 1'b0; pop_i = 1'b0;
    check(tag);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset");
    rst_ni = 1'b1;
    step(0, 1, 16'h0, "R4 underflow on empty");
    step(1, 0, 16'h1111, "R2 push 1");
    step(1, 0, 16'h2222, "R2 push 2");
    step(0, 1, 16'h0, "R3 pop top");
    step(1, 0, 16'h3333, "R2 push after pop");
    step(1, 0, 16'h4444, "R2 push");
    step(1, 0, 16'h5555, "R2 push");
    step(1, 0, 16'h6666, "R7 push to full");
    step(1, 0, 16'h7777, "R5 overflow");
    step(1, 1, 16'h8888, "R8 both at full, push wins and is refused");
    step(0, 0, 16'h0, "R8 idle no ack");
    for (int i = 0; i < 5; i++) step(0, 1, 16'h0, "R6 drain order");
    step(0, 1, 16'h0, "R4 underflow after drain");
    step(1, 0, 16'h9999, "R9 push keeps rdata");
    step(1, 1, 16'hAAAA, "R8 both, pop dropped");
    step(0, 1, 16'h0, "R3 pop after simultaneous");
    step(0, 1, 16'h0, "R6 pop remaining");
    step(0, 1, 16'h0, "R9 refused pop keeps rdata");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & ~lfsr[5], lfsr[1] | lfsr[9], lfsr ^ 16'h5A5A, "R7 mixed traffic");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule